// File: doc/BRIEF.md
# Randomized Datagram Repeat Scheduler

This block paces one datagram built from several copies of the same data frame. When a datagram is requested, the block waits an initial gap and then triggers the frame serializer. After each frame it waits a further gap before it triggers the next copy. Each gap sums a programmable base count, a pseudorandom count and, between frames, a term that grows with the frame index. The random term keeps two free-running transmitters from colliding on every repeat.

While a gap is being timed, the block marks the radio as silent, which is the same as sending zeros. If the power-down option was selected for the datagram, it also requests that the oscillator and synthesizer be switched off. The frame contents and the radio itself lie outside the block. The block only issues a one-cycle start pulse per frame and waits for the serializer's completion pulse.

Top module: `dgram_sched`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `frame_start`, `space_active`, `pwr_down`, `busy` and `dgram_done` are all 0.
- R2: A datagram accepted with `frame_cnt_m1 = n` produces exactly n+1 `frame_start` pulses. Each pulse lasts one cycle. After the first pulse, each further pulse comes only after a `frame_done` pulse for the previous frame. No further pulse follows the last frame.
- R3: The initial gap lasts base + 40·r + 1 cycles, counted as cycles with `space_active` high. It begins in the cycle after `start` is sampled. `frame_start` rises in the cycle after the gap ends. Here r is the low 8 bits of the pseudorandom register.
- R4: After `frame_done` for the frame with zero-based index k-1, the next gap lasts base + r + k·unit + 1 cycles of `space_active`. It starts in the cycle after `frame_done` is sampled. r is taken as in R3.
- R5: The pseudorandom register is 16 bits wide. It shifts toward the MSB, and the XOR of bits 15, 13, 12 and 10 enters bit 0. It advances once each time a gap length is taken, and r is taken before the advance. Its reset value is 16'h0001. A `seed_load` pulse writes `seed` into it, and a zero seed is written as 16'h0001.
- R6: `space_active` is high during every gap cycle and low while a frame is in progress and while the block is idle.
- R7: During every gap cycle, `pwr_down` equals the `pd_en` value sampled with `start`.
- R8: In the cycle after the last `frame_done` is sampled, `dgram_done` is 1 and `busy` is 0. `dgram_done` stays 1 until the next accepted `start`, which clears it.
- R9: `start` is ignored while `busy` is 1. Changes to `frame_cnt_m1`, `base_time`, `fn_unit` or `pd_en` after `start` is accepted have no effect on the running datagram.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_load | input | 1 | Write `seed` into the pseudorandom register |
| seed | input | 16 | Seed value; zero is replaced by 1 |
| start | input | 1 | Begin a datagram (sampled when idle) |
| frame_cnt_m1 | input | FN_W (4) | Number of frames minus one |
| base_time | input | BASE_W (16) | Base gap count in cycles |
| fn_unit | input | UNIT_W (8) | Per-frame-index gap increment |
| pd_en | input | 1 | Request power-down during gaps |
| frame_done | input | 1 | Serializer finished the current frame |
| frame_start | output | 1 | One-cycle trigger to the serializer |
| space_active | output | 1 | Carrier off, gap being timed |
| pwr_down | output | 1 | Oscillator/synthesizer off request |
| busy | output | 1 | Datagram in progress |
| dgram_done | output | 1 | Last frame of the datagram completed |

## Verification
The assertions check four properties on every cycle: a frame trigger never lasts more than one cycle, it never overlaps a gap, the frame index never passes the latched count, and the pseudorandom register never reaches zero. They also check that the done flag is always up when the block drops out of busy. Only the bench scenarios can show the exact gap lengths under each weighting, because those depend on the register sequence and the latched base and unit values. The same holds for the frame count, the sampling of the power-down choice, and the rejection of a mid-datagram restart or configuration change.

// File: rtl/dgs_pkg.sv
package dgs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SPACE = 2'd1,
    ST_FRAME = 2'd2
  } dgs_state_e;
endpackage

// File: rtl/dgs_lfsr.sv
module dgs_lfsr #(
  parameter int RAND_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [15:0]       seed,
  input  logic              adv,
  output logic [RAND_W-1:0] rnd
);
  logic [15:0] q;
  logic        fb;

  assign fb  = q[15] ^ q[13] ^ q[12] ^ q[10];
  assign rnd = q[RAND_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)       q <= 16'h0001;
    else if (load) q <= (seed == 16'h0000) ? 16'h0001 : seed;
    else if (adv)  q <= {q[14:0], fb};
  end

  // R5: the register must never lock up at zero
  a_r5_nonzero: assert property (@(posedge clk) disable iff (rst) q != 16'h0000);
  // R5: every advance changes the value
  a_r5_advances: assert property (@(posedge clk) disable iff (rst)
    (adv && !load) |=> (q != $past(q)));
endmodule

// File: rtl/dgs_interval.sv
module dgs_interval #(
  parameter int BASE_W     = 16,
  parameter int RAND_W     = 8,
  parameter int UNIT_W     = 8,
  parameter int FN_W       = 4,
  parameter int INIT_SCALE = 40,
  parameter int IV_W       = BASE_W + RAND_W + UNIT_W + FN_W
) (
  input  logic              is_init,
  input  logic [BASE_W-1:0] base,
  input  logic [RAND_W-1:0] rnd,
  input  logic [FN_W-1:0]   idx,
  input  logic [UNIT_W-1:0] unit,
  output logic [IV_W-1:0]   iv
);
  logic [IV_W-1:0] t_base, t_init, t_rand, t_fn;

  always_comb begin
    t_base = IV_W'(base);
    t_init = IV_W'(rnd) * IV_W'(INIT_SCALE);
    t_rand = IV_W'(rnd);
    t_fn   = IV_W'(idx) * IV_W'(unit);
    iv     = is_init ? (t_base + t_init) : (t_base + t_rand + t_fn);
  end
endmodule

// File: rtl/dgram_sched.sv
module dgram_sched
  import dgs_pkg::*;
#(
  parameter int BASE_W     = 16,
  parameter int UNIT_W     = 8,
  parameter int RAND_W     = 8,
  parameter int FN_W       = 4,
  parameter int INIT_SCALE = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seed_load,
  input  logic [15:0]       seed,
  input  logic              start,
  input  logic [FN_W-1:0]   frame_cnt_m1,
  input  logic [BASE_W-1:0] base_time,
  input  logic [UNIT_W-1:0] fn_unit,
  input  logic              pd_en,
  input  logic              frame_done,
  output logic              frame_start,
  output logic              space_active,
  output logic              pwr_down,
  output logic              busy,
  output logic              dgram_done
);
  localparam int IV_W = BASE_W + RAND_W + UNIT_W + FN_W;

  dgs_state_e        state;
  logic [IV_W-1:0]   cnt;
  logic [FN_W-1:0]   fidx, nf_lat;
  logic [BASE_W-1:0] base_lat;
  logic [UNIT_W-1:0] unit_lat;
  logic              pd_lat;

  logic              idle, accept, last_frame, next_frame, adv;
  logic [RAND_W-1:0] rnd;
  logic [IV_W-1:0]   iv;
  logic [BASE_W-1:0] base_sel;
  logic [UNIT_W-1:0] unit_sel;

  assign idle       = (state == ST_IDLE);
  assign accept     = idle && start;
  assign last_frame = (fidx == nf_lat);
  assign next_frame = (state == ST_FRAME) && frame_done && !last_frame;
  assign adv        = accept || next_frame;
  assign base_sel   = idle ? base_time : base_lat;
  assign unit_sel   = idle ? fn_unit   : unit_lat;

  dgs_lfsr #(.RAND_W(RAND_W)) u_lfsr (
    .clk(clk), .rst(rst), .load(seed_load), .seed(seed), .adv(adv), .rnd(rnd)
  );

  dgs_interval #(
    .BASE_W(BASE_W), .RAND_W(RAND_W), .UNIT_W(UNIT_W), .FN_W(FN_W),
    .INIT_SCALE(INIT_SCALE), .IV_W(IV_W)
  ) u_iv (
    .is_init(idle), .base(base_sel), .rnd(rnd), .idx(fidx + 1'b1),
    .unit(unit_sel), .iv(iv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      fidx        <= '0;
      nf_lat      <= '0;
      base_lat    <= '0;
      unit_lat    <= '0;
      pd_lat      <= 1'b0;
      frame_start <= 1'b0;
      dgram_done  <= 1'b0;
    end else begin
      frame_start <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          nf_lat     <= frame_cnt_m1;
          base_lat   <= base_time;
          unit_lat   <= fn_unit;
          pd_lat     <= pd_en;
          fidx       <= '0;
          dgram_done <= 1'b0;
          cnt        <= iv;
          state      <= ST_SPACE;
        end
        ST_SPACE: if (cnt == '0) begin
          frame_start <= 1'b1;
          state       <= ST_FRAME;
        end else begin
          cnt <= cnt - 1'b1;
        end
        ST_FRAME: if (frame_done) begin
          if (last_frame) begin
            dgram_done <= 1'b1;
            state      <= ST_IDLE;
          end else begin
            fidx  <= fidx + 1'b1;
            cnt   <= iv;
            state <= ST_SPACE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign space_active = (state == ST_SPACE);
  assign pwr_down     = space_active && pd_lat;
  assign busy         = !idle;

  // R2: the serializer trigger is a single-cycle pulse
  a_r2_pulse: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);
  // R2: frame index never passes the latched count
  a_r2_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> (fidx <= nf_lat));
  // R6: a trigger never coincides with a gap
  a_r6_excl: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> !space_active);
  // R8: leaving busy always leaves the done flag up
  a_r8_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> dgram_done);
endmodule

// File: tb/sim_dgram_sched.sv
module sim_dgram_sched;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        seed_load = 1'b0;
  logic [15:0] seed = '0;
  logic        start = 1'b0;
  logic [3:0]  frame_cnt_m1 = '0;
  logic [15:0] base_time = '0;
  logic [7:0]  fn_unit = '0;
  logic        pd_en = 1'b0;
  logic        frame_done = 1'b0;
  logic        frame_start, space_active, pwr_down, busy, dgram_done;

  int errors = 0;
  int checks = 0;
  logic [15:0] mdl = 16'h0001;

  always #2 clk = ~clk;

  dgram_sched u0 (
    .clk(clk), .rst(rst), .seed_load(seed_load), .seed(seed), .start(start),
    .frame_cnt_m1(frame_cnt_m1), .base_time(base_time), .fn_unit(fn_unit),
    .pd_en(pd_en), .frame_done(frame_done), .frame_start(frame_start),
    .space_active(space_active), .pwr_down(pwr_down), .busy(busy),
    .dgram_done(dgram_done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] step(input logic [15:0] m);
    return {m[14:0], m[15] ^ m[13] ^ m[12] ^ m[10]};
  endfunction

  task automatic load_seed(input logic [15:0] s);
    @(negedge clk); seed = s; seed_load = 1'b1;
    @(negedge clk); seed_load = 1'b0;
    mdl = (s == 16'h0000) ? 16'h0001 : s; // R5 zero seed maps to 1
  endtask

  // One datagram: R2 R3 R4 R6 R7 R8 R9
  task automatic run(input int nfr, input int base, input int unit, input bit pd, input bit poke);
    int pd_bad, pulses;
    longint cnt, exp_len;
    frame_cnt_m1 = 4'(nfr - 1); base_time = 16'(base); fn_unit = 8'(unit); pd_en = pd;
    @(negedge clk); start = 1'b1;
    for (int f = 0; f < nfr; f++) begin
      int rr = int'(mdl[7:0]);
      mdl = step(mdl);
      exp_len = (f == 0) ? longint'(base + 40 * rr + 1) : longint'(base + rr + f * unit + 1);
      cnt = 0; pd_bad = 0;
      forever begin
        @(negedge clk); start = 1'b0; frame_done = 1'b0;
        if (f == 0 && cnt == 0) begin
          chk(dgram_done == 1'b0, "R8 cleared by start", dgram_done, 0);
          // R9: scramble configuration after acceptance
          frame_cnt_m1 = ~frame_cnt_m1; base_time = base_time + 16'd7;
          fn_unit = fn_unit + 8'd3; pd_en = !pd;
        end
        if (poke && f == 1 && cnt == 1) start = 1'b1; // R9 start while busy
        if (frame_start) break;
        if (space_active) begin
          cnt++;
          if (pwr_down !== pd) pd_bad++;
        end
      end
      if (f == 0) chk(cnt == exp_len, "R3 initial gap", cnt, exp_len);
      else        chk(cnt == exp_len, poke ? "R4/R9 gap after restart poke" : "R4 interframe gap", cnt, exp_len);
      chk(pd_bad == 0, "R7 pwr_down during gap", pd_bad, 0);
      @(negedge clk); start = 1'b0;
      chk(!frame_start && !space_active && busy, "R2/R6 single pulse, frame in progress",
          {frame_start, space_active, busy}, 3'b001);
      @(negedge clk); frame_done = 1'b1;
    end
    @(negedge clk); frame_done = 1'b0;
    chk(dgram_done && !busy, "R8 done after last frame", {dgram_done, busy}, 2'b10);
    pulses = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (frame_start || space_active) pulses++;
    end
    chk(pulses == 0, "R2 no extra frame", pulses, 0);
    chk(dgram_done == 1'b1, "R8 done holds", dgram_done, 1);
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk({frame_start, space_active, pwr_down, busy, dgram_done} == 5'b0, "R1 in reset",
        {frame_start, space_active, pwr_down, busy, dgram_done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({frame_start, space_active, pwr_down, busy, dgram_done} == 5'b0, "R1 after reset",
        {frame_start, space_active, pwr_down, busy, dgram_done}, 0);
    mdl = 16'h0001;
  endtask

  initial begin
    test_reset();
    run(1, 5, 0, 1'b1, 1'b0);      // R5 reset value used, single frame
    load_seed(16'h0000);           // R5 zero seed
    run(3, 2, 4, 1'b0, 1'b0);
    load_seed(16'hACE1);
    run(4, 3, 2, 1'b0, 1'b0);
    run(16, 0, 1, 1'b1, 1'b0);     // R2 maximum frame count
    run(2, 1, 9, 1'b1, 1'b1);      // R9 restart attempt while busy
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule